// File: doc/BRIEF.md
# Debounced sequence step detector

This block tells a supply sequencing state machine when its current step is finished. It picks one bit out of a vector of monitored flags. The bits can be supply-good indications or plain logic inputs. The block can flip the chosen bit's polarity and compares the result with a wanted level. The step counts as finished only after that match has held without a break for a programmed dwell time. If the match breaks at any point, the dwell count goes back to zero. A force option ignores the input altogether, so the block becomes a plain delay followed by an unconditional jump.

The dwell time is set in ticks of about 10 µs. A prescaler divides the system clock down to that tick (PRESCALE cycles per tick), and a 16-bit tick count follows it, so a count of 40000 gives 400 ms. The sequencer pulses `stateEntry` once each time it enters a state. That pulse clears any time already counted and arms the detector. The detector then gives one single-cycle `stepDone` pulse and stays silent until the next `stateEntry`.

Top module: `seq_step_detect`

## Requirements
- R1: After reset `stepDone` is low and the detector is unarmed, so no pulse appears until a `stateEntry` strobe is given, even when the input matches.
- R2: Only the flag whose index equals `selIdx` (bit `selIdx` of `flags`) is used. All other flag bits have no effect on `stepDone`.
- R3: The selected flag is XORed with `invertEn` before it is compared with `targetLvl`. A match means the XOR result equals `targetLvl`.
- R4: With a continuous match from the strobe on, `stepDone` is high in exactly the cycle after rising edge number `delayTicks*PRESCALE+1`, counted from the edge that samples `stateEntry` high.
- R5: A cycle without a match while the detector is armed clears the dwell count. The pulse then comes `delayTicks*PRESCALE+1` edges after the edge that sampled the mismatch.
- R6: With `forceFlow` high the input level is ignored, and the pulse comes after the programmed delay as in R4.
- R7: With `delayTicks` equal to 0, the pulse comes one edge after the first armed cycle with a match.
- R8: `stepDone` is high for exactly one cycle. It then stays low while the input keeps matching, until a new `stateEntry` re-arms the detector.
- R9: A `stateEntry` strobe in the middle of a count restarts the dwell from zero, and `stepDone` is low in the cycle after any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| flags | input | NUM_INPUTS | Monitored supply-good flags and logic inputs |
| selIdx | input | SEL_W | Index of the flag to watch |
| invertEn | input | 1 | Invert the selected flag before comparing |
| targetLvl | input | 1 | Level the qualified flag must reach |
| forceFlow | input | 1 | Ignore the input and fire on the delay alone |
| delayTicks | input | DELAY_W | Dwell time in prescaled ticks |
| stateEntry | input | 1 | One-cycle strobe on entry into a sequencer state |
| stepDone | output | 1 | One-cycle pulse when the step is complete |

## Verification
The bench measures the pulse latency edge by edge. A detector that is off by one in the prescaler wrap or in the done register would fire one cycle early or late. A single mismatch cycle and a strobe placed in the middle of a count must both push the pulse back to a full dwell after the event. A design that only paused the count, or that kept time from the earlier state, would fire at the original time. After a pulse the bench keeps the input matching, and a detector that re-fired or held the pulse high shows up as extra pulses. Vectors that differ only in unselected flags or in the invert bit show whether the select and the polarity are applied correctly.

// File: rtl/seq_step_pkg.sv
package seq_step_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic advance;
  } step_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic qualified;
    logic expired;
  } step_stat_t;
endpackage

// File: rtl/step_datapath.sv
module step_datapath
  import seq_step_pkg::*;
#(
  parameter int NUM_INPUTS = 8,
  parameter int DELAY_W    = 16,
  parameter int PRESCALE   = 2000,
  localparam int SEL_W     = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_INPUTS-1:0] flags,
  input  logic [SEL_W-1:0]      selIdx,
  input  logic                  invertEn,
  input  logic                  targetLvl,
  input  logic                  forceFlow,
  input  logic [DELAY_W-1:0]    delayTicks,
  input  step_ctrl_t            ctrl,
  output step_stat_t            stat
);
  localparam int SEL_SPAN = 1 << SEL_W;
  localparam int PRE_W    = $clog2(PRESCALE + 1);

  logic [SEL_SPAN-1:0] padded;
  logic                pickedBit;
  logic [PRE_W-1:0]    presc;
  logic [DELAY_W-1:0]  tickCnt;

  // widen the flag vector so any select code addresses a defined bit
  generate
    if (SEL_SPAN == NUM_INPUTS) begin : g_exact
      assign padded = flags;
    end else begin : g_pad
      assign padded = {{(SEL_SPAN - NUM_INPUTS){1'b0}}, flags};
    end
  endgenerate

  assign pickedBit      = padded[selIdx];
  assign stat.qualified = forceFlow | ((pickedBit ^ invertEn) == targetLvl);
  assign stat.expired   = (tickCnt >= delayTicks);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrTimer) begin
      presc   <= '0;
      tickCnt <= '0;
    end else if (ctrl.advance) begin
      if (presc == PRE_W'(PRESCALE - 1)) begin
        presc   <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  // R4: the tick count only steps up by one or restarts at zero
  p_tick_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tickCnt != $past(tickCnt)) |->
      ((tickCnt == $past(tickCnt) + 1'b1) || (tickCnt == '0)));
endmodule

// File: rtl/step_control.sv
module step_control
  import seq_step_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stateEntry,
  input  step_stat_t stat,
  output step_ctrl_t ctrl,
  output logic       stepDone
);
  logic armed;
  logic hit;

  assign hit           = armed & ~stateEntry & stat.qualified & stat.expired;
  assign ctrl.clrTimer = stateEntry | (armed & ~stat.qualified);
  assign ctrl.advance  = armed & stat.qualified & ~stat.expired;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= hit;
      if (stateEntry)  armed <= 1'b1;
      else if (hit)    armed <= 1'b0;
    end
  end

  // R8: the done pulse lasts one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !stepDone);

  // R9: a strobe never lets a pulse through in the next cycle
  p_quiet_after_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    stateEntry |=> !stepDone);

  // R5: an armed mismatch cycle blocks the pulse
  p_mismatch_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !stat.qualified) |=> !stepDone);
endmodule

// File: rtl/seq_step_detect.sv
module seq_step_detect
  import seq_step_pkg::*;
#(
  parameter int NUM_INPUTS = 8,
  parameter int DELAY_W    = 16,
  parameter int PRESCALE   = 2000,
  localparam int SEL_W     = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_INPUTS-1:0] flags,
  input  logic [SEL_W-1:0]      selIdx,
  input  logic                  invertEn,
  input  logic                  targetLvl,
  input  logic                  forceFlow,
  input  logic [DELAY_W-1:0]    delayTicks,
  input  logic                  stateEntry,
  output logic                  stepDone
);
  step_ctrl_t ctrl;
  step_stat_t stat;

  step_datapath #(
    .NUM_INPUTS(NUM_INPUTS),
    .DELAY_W   (DELAY_W),
    .PRESCALE  (PRESCALE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .flags     (flags),
    .selIdx    (selIdx),
    .invertEn  (invertEn),
    .targetLvl (targetLvl),
    .forceFlow (forceFlow),
    .delayTicks(delayTicks),
    .ctrl      (ctrl),
    .stat      (stat)
  );

  step_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stateEntry(stateEntry),
    .stat      (stat),
    .ctrl      (ctrl),
    .stepDone  (stepDone)
  );
endmodule

// File: tb/seq_step_detect_tb.sv
module seq_step_detect_tb;
  localparam int P  = 4;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  flags = '0;
  logic [2:0]  selIdx = '0;
  logic        invertEn = 1'b0;
  logic        targetLvl = 1'b0;
  logic        forceFlow = 1'b0;
  logic [15:0] delayTicks = '0;
  logic        stateEntry = 1'b0;
  logic        stepDone;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  seq_step_detect #(.NUM_INPUTS(8), .DELAY_W(16), .PRESCALE(P)) u_dut (
    .clk(clk), .rstN(rstN), .flags(flags), .selIdx(selIdx),
    .invertEn(invertEn), .targetLvl(targetLvl), .forceFlow(forceFlow),
    .delayTicks(delayTicks), .stateEntry(stateEntry), .stepDone(stepDone)
  );

  // {flags, sel, inv, tgt, force, delay, expectFire}
  localparam logic [30:0] VEC [NV] = '{
    {8'b0000_0100, 3'd2, 1'b0, 1'b1, 1'b0, 16'd3, 1'b1}, // R2 match on bit 2
    {8'b1111_1011, 3'd2, 1'b0, 1'b1, 1'b0, 16'd2, 1'b0}, // R2 others set, bit 2 low
    {8'b0000_0000, 3'd5, 1'b1, 1'b1, 1'b0, 16'd1, 1'b1}, // R3 inverted low matches
    {8'b1111_1111, 3'd0, 1'b1, 1'b1, 1'b0, 16'd1, 1'b0}, // R3 inverted high fails
    {8'b0000_0000, 3'd7, 1'b0, 1'b1, 1'b1, 16'd2, 1'b1}, // R6 forced
    {8'b1000_0000, 3'd7, 1'b0, 1'b0, 1'b0, 16'd0, 1'b0}, // R3 target low not met
    {8'b1000_0000, 3'd7, 1'b0, 1'b1, 1'b0, 16'd0, 1'b1}, // R7 zero delay
    {8'b0000_0000, 3'd3, 1'b0, 1'b0, 1'b0, 16'd5, 1'b1}  // R4 target low
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) stateEntry = 1'b1;
    @(negedge clk) stateEntry = 1'b0;
  endtask

  // observe limit edges after the strobe; first = first edge index with done, cnt = pulses
  task automatic observe(input int limit, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      if (stepDone) begin
        cnt++;
        if (first < 0) first = j;
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        summary();
        $finish;
      end
    end
  end

  initial begin
    int first, cnt;
    // R1 reset state and no pulse without a strobe
    flags = 8'hFF; selIdx = 3'd0; targetLvl = 1'b1; delayTicks = 16'd0;
    repeat (4) @(negedge clk);
    check(stepDone == 1'b0, "R1 during reset", int'(stepDone), 0);
    rstN = 1'b1;
    observe(20, first, cnt);
    check(cnt == 0, "R1 unarmed after reset", cnt, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      int expAt;
      @(negedge clk);
      flags = VEC[i][30:23]; selIdx = VEC[i][22:20]; invertEn = VEC[i][19];
      targetLvl = VEC[i][18]; forceFlow = VEC[i][17]; delayTicks = VEC[i][16:1];
      stateEntry = 1'b1;
      @(negedge clk) stateEntry = 1'b0;
      check(stepDone == 1'b0, "R9 quiet after strobe", int'(stepDone), 0);
      expAt = int'(VEC[i][16:1]) * P + 1;
      observe(expAt + 8, first, cnt);
      if (VEC[i][0]) begin
        check(first == expAt, $sformatf("R4 vector %0d latency", i), first, expAt);
        check(cnt == 1, $sformatf("R8 vector %0d pulses", i), cnt, 1);
      end else begin
        check(cnt == 0, $sformatf("R2/R3 vector %0d no fire", i), cnt, 0);
      end
    end

    // R6 forced with input opposite the target: exact latency
    flags = 8'h00; selIdx = 3'd1; invertEn = 1'b0; targetLvl = 1'b1;
    forceFlow = 1'b1; delayTicks = 16'd4;
    strobe();
    observe(4 * P + 6, first, cnt);
    check(first == 4 * P + 1, "R6 forced latency", first, 4 * P + 1);
    forceFlow = 1'b0;

    // R5 one mismatch cycle restarts the dwell
    flags = 8'h02; delayTicks = 16'd3;
    strobe();
    first = -1;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      if (stepDone && first < 0) first = j;
      if (j == 5) flags = 8'h00;
      if (j == 6) flags = 8'h02;
    end
    check(first == 5 + 1 + 3 * P + 1, "R5 restart after mismatch", first, 5 + 1 + 3 * P + 1);

    // R9 a mid-count strobe restarts the dwell
    strobe();
    first = -1;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      if (stepDone && first < 0) first = j;
      stateEntry = (j == 5);
    end
    check(first == 5 + 1 + 3 * P + 1, "R9 restart on strobe", first, 5 + 1 + 3 * P + 1);

    // R8 no refire while matching, then a new strobe re-arms
    observe(30, first, cnt);
    check(cnt == 0, "R8 silent after pulse", cnt, 0);
    strobe();
    observe(3 * P + 4, first, cnt);
    check(first == 3 * P + 1, "R8 re-armed latency", first, 3 * P + 1);

    // R7 zero delay after a long unmatched wait
    flags = 8'h00; delayTicks = 16'd0;
    strobe();
    observe(10, first, cnt);
    check(cnt == 0, "R7 no match no fire", cnt, 0);
    @(negedge clk) flags = 8'h02;
    observe(4, first, cnt);
    check(first == 1, "R7 zero delay on first match", first, 1);

    summary();
    $finish;
  end
endmodule